// File: doc/BRIEF.md
# Trigger Busy Generator

This block drives the BUSY level that tells the trigger system to hold off. A one-cycle L0 pulse starts a programmable hold interval, counted in coarse ticks produced by dividing the system clock. With a 25 ns clock and the default divider of 400, one tick is 10 microseconds. The hold value resets to 10 ticks, which gives 100 microseconds. A buffers-full level from the readout side keeps BUSY high for as long as it is present, whatever state the hold interval is in.

A 32-bit counter adds one for every clock cycle in which BUSY is high, and a clear strobe returns it to zero. Software reaches the hold register and the counter through a small word-wide register port. Reading the low half of the counter captures the high half at the same instant, so a low-then-high read pair gives one consistent 32-bit value.

Top module: `trig_busy_gen`

## Requirements
- R1: After reset BUSY is low, the busy-time counter is 0 and the hold register reads 0x000A.
- R2: When an L0 pulse arrives with a nonzero hold value H, BUSY is high from the next clock edge for exactly H × TICK_CYCLES cycles, provided buffers-full stays low.
- R3: An L0 pulse while the hold interval is running reloads it, so BUSY ends H × TICK_CYCLES cycles after the most recent pulse.
- R4: With a hold value of 0, an L0 pulse is ignored and BUSY stays low.
- R5: BUSY is high in every cycle in which buffers-full is high, with no cycle of delay, including after the hold interval has expired. Once buffers-full drops after the hold interval has ended, BUSY falls in the same cycle.
- R6: The busy-time counter increments by one at every clock edge at which BUSY is high. It therefore equals the number of BUSY-high cycles since the last clear.
- R7: A clear strobe sets the counter to 0 at the next edge, and takes priority over an increment in that same cycle.
- R8: Read data appears one cycle after the read enable. Address 2 returns counter bits 15:0 and at the same time latches counter bits 31:16. Address 1 returns that latched value, not the live upper half.
- R9: Address 0 is the 16-bit hold register and can be written and read back. Address 3 reads 0.
- R10: One tick lasts TICK_CYCLES clock cycles (default 400). The tick divider restarts on every accepted L0 pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| l0Pulse | input | 1 | One-cycle L0 trigger pulse |
| bufFull | input | 1 | Readout buffers-full level |
| cntClr | input | 1 | Clear strobe for the busy-time counter |
| regAddr | input | 2 | Register address (0 hold, 1 counter high latch, 2 counter low, 3 none) |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 16 | Register write data |
| regRdEn | input | 1 | Register read strobe |
| regRdData | output | 16 | Registered read data, valid the cycle after regRdEn |
| busy | output | 1 | BUSY level to the trigger system |

## Verification
BUSY responds to buffers-full in the same cycle, so the bench checks it shortly after changing that input, between clock edges. An accepted L0 pulse raises BUSY at the edge that samples it. The bench therefore starts counting BUSY-high cycles at the first falling edge after the pulse and compares the total with the hold value times the divider. Counter reads are issued while BUSY is steady, and the data is taken one cycle after the read strobe, when the register port has updated its output.

// File: rtl/busy_pkg.sv
package busy_pkg;

  localparam logic [1:0] ADDR_HOLD = 2'd0;
  localparam logic [1:0] ADDR_HI   = 2'd1;
  localparam logic [1:0] ADDR_LO   = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic       wrHold;
    logic       rdEn;
    logic [1:0] rdAddr;
    logic       snapHi;
    logic       cntInc;
    logic       cntClr;
  } busyStrobes_t;

endpackage

// File: rtl/busy_ctrl.sv
module busy_ctrl
  import busy_pkg::*;
#(
  parameter int TICK_CYCLES = 400,
  parameter int HOLD_W      = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              l0Pulse,
  input  logic              bufFull,
  input  logic              cntClr,
  input  logic [1:0]        regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [HOLD_W-1:0] holdVal,
  output logic              busy,
  output busyStrobes_t      strb
);

  localparam int PRE_W = $clog2(TICK_CYCLES);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_CYCLES - 1);

  logic [PRE_W-1:0]  preCnt;
  logic [HOLD_W-1:0] holdCnt;
  logic              holdActive;
  logic              l0Accept;

  assign holdActive = (holdCnt != '0);
  assign l0Accept   = l0Pulse && (holdVal != '0);

  // hold countdown with a divider that restarts on each accepted L0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      holdCnt <= '0;
    end else if (l0Accept) begin
      preCnt  <= '0;
      holdCnt <= holdVal;
    end else if (holdActive) begin
      if (preCnt == PRE_LAST) begin
        preCnt  <= '0;
        holdCnt <= holdCnt - 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  assign busy = holdActive | bufFull;

  always_comb begin
    strb.wrHold = regWrEn && (regAddr == ADDR_HOLD);
    strb.rdEn   = regRdEn;
    strb.rdAddr = regAddr;
    strb.snapHi = regRdEn && (regAddr == ADDR_LO);
    strb.cntInc = busy;
    strb.cntClr = cntClr;
  end

  assert_l0_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (l0Pulse && holdVal != '0) |=> (holdCnt == $past(holdVal) && preCnt == '0));

  assert_reload_R3: assert property (@(posedge clk) disable iff (!rstN)
    (l0Pulse && holdActive && holdVal != '0) |=> holdCnt == $past(holdVal));

  assert_zero_hold_ignored_R4: assert property (@(posedge clk) disable iff (!rstN)
    (l0Pulse && holdVal == '0 && !holdActive) |=> !holdActive);

  assert_full_forces_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    bufFull |-> busy);

  assert_prescale_range_R10: assert property (@(posedge clk) disable iff (!rstN)
    preCnt <= PRE_LAST);

  assert_idle_divider_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!holdActive && !l0Pulse) |=> $stable(preCnt));

endmodule

// File: rtl/busy_dpath.sv
module busy_dpath
  import busy_pkg::*;
#(
  parameter int          REG_W    = 16,
  parameter logic [15:0] HOLD_RST = 16'h000A
) (
  input  logic             clk,
  input  logic             rstN,
  input  busyStrobes_t     strb,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] holdVal,
  output logic [REG_W-1:0] rdData
);

  localparam int CNT_W = 2 * REG_W;

  logic [REG_W-1:0] holdReg;
  logic [CNT_W-1:0] busyTime;
  logic [REG_W-1:0] snapHi;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdReg <= REG_W'(HOLD_RST);
    else if (strb.wrHold) holdReg <= wrData;
  end

  assign holdVal = holdReg;

  // clear wins over increment
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyTime <= '0;
    else if (strb.cntClr) busyTime <= '0;
    else if (strb.cntInc) busyTime <= busyTime + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) snapHi <= '0;
    else if (strb.snapHi) snapHi <= busyTime[CNT_W-1:REG_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strb.rdEn) begin
      case (strb.rdAddr)
        ADDR_HOLD: rdData <= holdReg;
        ADDR_HI:   rdData <= snapHi;
        ADDR_LO:   rdData <= busyTime[REG_W-1:0];
        default:   rdData <= '0;
      endcase
    end
  end

  assert_cnt_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cntInc && !strb.cntClr) |=> busyTime == $past(busyTime) + 1'b1);

  assert_cnt_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.cntInc && !strb.cntClr) |=> $stable(busyTime));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntClr |=> busyTime == '0);

  assert_snapshot_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.snapHi |=> snapHi == $past(busyTime[CNT_W-1:REG_W]));

  assert_hold_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrHold |=> holdReg == $past(wrData));

endmodule

// File: rtl/trig_busy_gen.sv
module trig_busy_gen
  import busy_pkg::*;
#(
  parameter int          TICK_CYCLES = 400,
  parameter int          REG_W       = 16,
  parameter logic [15:0] HOLD_RST    = 16'h000A
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             l0Pulse,
  input  logic             bufFull,
  input  logic             cntClr,
  input  logic [1:0]       regAddr,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  input  logic             regRdEn,
  output logic [REG_W-1:0] regRdData,
  output logic             busy
);

  busyStrobes_t     strb;
  logic [REG_W-1:0] holdVal;

  busy_ctrl #(
    .TICK_CYCLES (TICK_CYCLES),
    .HOLD_W      (REG_W)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .l0Pulse (l0Pulse),
    .bufFull (bufFull),
    .cntClr  (cntClr),
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .holdVal (holdVal),
    .busy    (busy),
    .strb    (strb)
  );

  busy_dpath #(
    .REG_W    (REG_W),
    .HOLD_RST (HOLD_RST)
  ) uDpath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (regWrData),
    .holdVal (holdVal),
    .rdData  (regRdData)
  );

endmodule

// File: tb/sim_trig_busy_gen.sv
`timescale 1ns/1ps
module sim_trig_busy_gen;

  localparam int TICK = 400;
  localparam int NVEC = 5;
  localparam logic [15:0] VEC_HOLD [NVEC] = '{16'd1, 16'd3, 16'd0, 16'd2, 16'd5};
  localparam int          VEC_EXP  [NVEC] = '{400, 1200, 0, 800, 2000};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        l0Pulse = 1'b0;
  logic        bufFull = 1'b0;
  logic        cntClr = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = 16'h0;
  logic        regRdEn = 1'b0;
  logic [15:0] regRdData;
  logic        busy;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  trig_busy_gen #(.TICK_CYCLES(TICK)) u0 (
    .clk(clk), .rstN(rstN), .l0Pulse(l0Pulse), .bufFull(bufFull),
    .cntClr(cntClr), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData),
    .busy(busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output int v);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    @(negedge clk);
    regRdEn = 1'b0;
    v = int'(regRdData);
  endtask

  task automatic clearCnt();
    @(negedge clk);
    cntClr = 1'b1;
    @(negedge clk);
    cntClr = 1'b0;
  endtask

  task automatic pulseL0();
    @(negedge clk);
    l0Pulse = 1'b1;
    @(negedge clk);
    l0Pulse = 1'b0;
  endtask

  // called right after pulseL0: counts BUSY-high falling edges
  task automatic countBusy(output int n);
    n = 0;
    while (busy && n < 100000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int v;
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    regRead(2'd0, v); chk("R1 hold", v, 16'h000A);
    regRead(2'd2, v); chk("R1 cnt lo", v, 0);
    regRead(2'd1, v); chk("R1 cnt hi", v, 0);

    // R2 R4 R6 R10: table of hold values and expected busy lengths
    for (int i = 0; i < NVEC; i++) begin
      regWrite(2'd0, VEC_HOLD[i]);
      clearCnt();
      pulseL0();
      countBusy(n);
      chk(VEC_HOLD[i] == 0 ? "R4 length" : "R2 R10 length", n, VEC_EXP[i]);
      regRead(2'd2, v);
      chk("R6 count", v, VEC_EXP[i]);
    end

    // R3 reload while busy
    regWrite(2'd0, 16'd2);
    pulseL0();
    repeat (500) @(negedge clk);
    chk("R3 still busy", int'(busy), 1);
    pulseL0();
    countBusy(n);
    chk("R3 reload length", n, 800);

    // R5 buffers-full
    regWrite(2'd0, 16'd1);
    @(negedge clk);
    bufFull = 1'b1;
    #1 chk("R5 immediate", int'(busy), 1);
    pulseL0();
    repeat (1000) @(negedge clk);
    chk("R5 past timeout", int'(busy), 1);
    bufFull = 1'b0;
    #1 chk("R5 release", int'(busy), 0);

    // R7 clear takes priority over increment
    @(negedge clk);
    bufFull = 1'b1;
    repeat (20) @(negedge clk);
    cntClr = 1'b1;
    @(negedge clk);
    cntClr = 1'b0;
    bufFull = 1'b0;
    regRead(2'd2, v); chk("R7 clear", v, 0);

    // R8 counter beyond 16 bits, latched high half
    clearCnt();
    @(negedge clk);
    bufFull = 1'b1;
    repeat (66000) @(posedge clk);
    @(negedge clk);
    bufFull = 1'b0;
    regRead(2'd2, v); chk("R8 lo", v, 66000 & 16'hFFFF);
    regRead(2'd1, v); chk("R8 hi", v, 66000 >> 16);
    clearCnt();
    regRead(2'd1, v); chk("R8 hi latched", v, 1);

    // R9 register access
    regWrite(2'd0, 16'hBEEF);
    regRead(2'd0, v); chk("R9 readback", v, 16'hBEEF);
    regRead(2'd3, v); chk("R9 unused addr", v, 0);
    regWrite(2'd0, 16'd0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule